// File: doc/BRIEF.md
# Three-Address Expanded Register File

This block is a scratchpad for a bit-slice datapath. It holds 64 words and is built from four identical 16-word banks. Two read ports return the words at a first and a second source address. A third, independent destination address can be written in the same operation because of a latching phase.

While the latch control `le` is high, each rising clock edge loads `ya` with the word at `addr_a` and `yb` with the word at `addr_b`. When `le` is low, both outputs keep their last values. The second port's address then switches to `addr_c`. An asserted `we` stores `din` at that destination on the clock edge. A microsequencer uses it in two steps. It first fetches the operands with `le` high. It then drops `le` and writes the result back, and the operands stay stable on the outputs.

The upper two address bits pick the bank and the lower four bits pick the word inside it. The word width is set by a parameter.

Top module: `xreg_file3`

## Requirements
- R1: While `rst_n` is low, `ya` and `yb` are zero and every stored word is cleared to zero.
- R2: With `le` high at a rising edge, `ya` shows the word at `addr_a` and `yb` shows the word at `addr_b` from that edge until the next update. Both reads use the contents from before the edge.
- R3: With `le` low at a rising edge, `ya` and `yb` keep their values unchanged.
- R4: With `le` low and `we` high at a rising edge, `din` is stored at `addr_c`.
- R5: With `le` high, `we` has no effect. No word changes and `addr_c` is ignored.
- R6: Address bits [5:4] select one of four 16-word banks and bits [3:0] select the word within the bank. Words that differ only in the bank bits are independent storage.
- R7: A write to an address that is currently held on `ya` or `yb` leaves the outputs at the pre-write data. The new value appears at the next read with `le` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| le | input | 1 | Latch control: high reads into outputs, low holds outputs and enables write |
| we | input | 1 | Write strobe, effective only with `le` low |
| addr_a | input | 6 | First read address |
| addr_b | input | 6 | Second read address |
| addr_c | input | 6 | Destination write address |
| din | input | W (4) | Write data |
| ya | output | W (4) | Word read at `addr_a` |
| yb | output | W (4) | Word read at `addr_b` |

## Verification
A corrupted word or a wrong bank decode stays hidden until that address is read with `le` high. It then shows on `ya` or `yb` one cycle after the read edge. The bench therefore reads back every destination it writes and compares against an array model. A wrong hold or address switch shows on the outputs within one cycle of `le` falling.

// File: rtl/xreg_file3.sv
module xreg_file3 #(
  parameter int W          = 4,
  parameter int BANK_WORDS = 16,
  parameter int NBANK      = 4,
  localparam int LO_W      = $clog2(BANK_WORDS),
  localparam int HI_W      = $clog2(NBANK),
  localparam int AW        = LO_W + HI_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          le,
  input  logic          we,
  input  logic [AW-1:0] addr_a,
  input  logic [AW-1:0] addr_b,
  input  logic [AW-1:0] addr_c,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  ya,
  output logic [W-1:0]  yb
);

  logic [AW-1:0]    port_b_addr;
  logic [NBANK-1:0] bank_we;
  logic [W-1:0]     rd_a_bank [NBANK];
  logic [W-1:0]     rd_b_bank [NBANK];
  logic [W-1:0]     rd_a, rd_b;

  assign port_b_addr = le ? addr_b : addr_c;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic [W-1:0] mem [BANK_WORDS];

    assign bank_we[g]   = we & ~le & (port_b_addr[AW-1:LO_W] == HI_W'(g));
    assign rd_a_bank[g] = mem[addr_a[LO_W-1:0]];
    assign rd_b_bank[g] = mem[port_b_addr[LO_W-1:0]];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < BANK_WORDS; i++) mem[i] <= '0;
      end else if (bank_we[g]) begin
        mem[port_b_addr[LO_W-1:0]] <= din;
      end
    end
  end

  assign rd_a = rd_a_bank[addr_a[AW-1:LO_W]];
  assign rd_b = rd_b_bank[port_b_addr[AW-1:LO_W]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ya <= '0;
      yb <= '0;
    end else if (le) begin
      ya <= rd_a;
      yb <= rd_b;
    end
  end

  // R3
  hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !le |=> ($stable(ya) && $stable(yb)));

  // R2
  read_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    le |=> (ya == $past(rd_a)));

  // R2
  read_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    le |=> (yb == $past(rd_b)));

  // R6
  one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we));

  // R5
  no_write_when_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    le |-> (bank_we == '0));

endmodule

// File: tb/sim_xreg_file3.sv
`timescale 1ns/1ps
module sim_xreg_file3;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       le = 1'b0, we = 1'b0;
  logic [5:0] addr_a = '0, addr_b = '0, addr_c = '0;
  logic [3:0] din = '0;
  logic [3:0] ya, yb;

  int vectors = 0;
  int fails = 0;
  logic [3:0] mdl [64];
  logic [3:0] eya, eyb;

  always #5 clk = ~clk;

  xreg_file3 u0 (.clk(clk), .rst_n(rst_n), .le(le), .we(we), .addr_a(addr_a),
                 .addr_b(addr_b), .addr_c(addr_c), .din(din), .ya(ya), .yb(yb));

  // {le, we, a, b, c, din, exp_ya, exp_yb}
  localparam logic [31:0] VEC [9] = '{
    {1'b0, 1'b1, 6'h05, 6'h00, 6'h05, 4'hA, 4'h0, 4'h0},
    {1'b0, 1'b1, 6'h00, 6'h00, 6'h15, 4'h3, 4'h0, 4'h0},
    {1'b0, 1'b1, 6'h00, 6'h00, 6'h25, 4'hC, 4'h0, 4'h0},
    {1'b0, 1'b1, 6'h00, 6'h00, 6'h35, 4'h7, 4'h0, 4'h0},
    {1'b1, 1'b1, 6'h05, 6'h15, 6'h25, 4'hF, 4'hA, 4'h3},
    {1'b1, 1'b0, 6'h25, 6'h35, 6'h00, 4'h0, 4'hC, 4'h7},
    {1'b0, 1'b1, 6'h00, 6'h00, 6'h25, 4'h1, 4'hC, 4'h7},
    {1'b1, 1'b0, 6'h25, 6'h05, 6'h00, 4'h0, 4'h1, 4'hA},
    {1'b1, 1'b0, 6'h15, 6'h35, 6'h00, 4'h0, 4'h3, 4'h7}
  };

  task automatic check(input string req, input logic [3:0] ea, input logic [3:0] eb);
    vectors++;
    if (ya !== ea || yb !== eb) begin
      fails++;
      $display("FAIL %s: ya=%h yb=%h expected ya=%h yb=%h", req, ya, yb, ea, eb);
    end
  endtask

  task automatic step(input logic l, input logic w, input logic [5:0] a,
                      input logic [5:0] b, input logic [5:0] c, input logic [3:0] d);
    le = l; we = w; addr_a = a; addr_b = b; addr_c = c; din = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: ya=%h yb=%h expected completion", ya, yb);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    #1;
    check("R1", 4'h0, 4'h0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 1'b0, 6'h3F, 6'h20, 6'h00, 4'h0);
    check("R1", 4'h0, 4'h0);

    // table: R2 reads, R3 hold, R4 write, R5 ignored write, R6 banks
    for (int i = 0; i < 9; i++) begin
      logic [31:0] v;
      v = VEC[i];
      step(v[31], v[30], v[29:24], v[23:18], v[17:12], v[11:8]);
      check("R2/R3/R4/R5/R6", v[7:4], v[3:0]);
    end

    // R7: write the held address, outputs keep old data
    step(1'b1, 1'b0, 6'h05, 6'h05, 6'h00, 4'h0);
    check("R7", 4'hA, 4'hA);
    step(1'b0, 1'b1, 6'h00, 6'h00, 6'h05, 4'h9);
    check("R7", 4'hA, 4'hA);
    step(1'b1, 1'b0, 6'h05, 6'h05, 6'h00, 4'h0);
    check("R7", 4'h9, 4'h9);

    // R5: le high with write strobe at unused address, then read it back
    step(1'b1, 1'b1, 6'h00, 6'h00, 6'h3A, 4'hE);
    step(1'b1, 1'b0, 6'h3A, 6'h0A, 6'h00, 4'h0);
    check("R5", 4'h0, 4'h0);

    // random sequence against array model (R2 R3 R4 R5 R6)
    for (int i = 0; i < 64; i++) mdl[i] = 4'h0;
    mdl[6'h05] = 4'h9; mdl[6'h15] = 4'h3; mdl[6'h25] = 4'h1; mdl[6'h35] = 4'h7;
    eya = 4'h0; eyb = 4'h0;
    for (int i = 0; i < 2000; i++) begin
      logic l, w;
      logic [5:0] a, b, c;
      logic [3:0] d;
      l = 1'($urandom); w = 1'($urandom);
      a = 6'($urandom); b = 6'($urandom); c = 6'($urandom); d = 4'($urandom);
      if (l) begin
        eya = mdl[a];
        eyb = mdl[b];
      end else if (w) begin
        mdl[c] = d;
      end
      step(l, w, a, b, c, d);
      check("R2/R3/R4 random", eya, eyb);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule